// File: doc/BRIEF.md
# Block-Multiplexed Stream Entry Gateway

This block lets several sample streams take turns on one chain of stream accelerators. Each stream has an input FIFO, a programmable block size and a consumer buffer at the far end of the chain. The gateway picks one stream at a time in rotating order and gives it the whole chain for one block of samples. It only grants a stream when three things hold: the chain has drained from the previous block, the stream's FIFO already holds a whole block, and the consumer has room for a whole block.

A grant runs in four phases. First the gateway writes the stream's saved accelerator context into the chain over a word-addressed configuration port. It then forwards exactly one block of samples, one per transfer and only while it holds a credit. Next it waits for the exit side to report that the chain is empty. Last it reads the accelerator context back into a small local store kept per stream. Because each block fully owns the chain, context never mixes between streams, and a sample enters the chain only when its block is known to fit at the consumer.

Top module: `stream_entry_gateway`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid`, `in_pop`, `cfg_we` and `cfg_re` are all low.
- R2: Stream s is eligible only when its block size n_s is nonzero, its input level is at least n_s and its reported consumer space is at least n_s. Equality is enough. A stream that fails any of these is never started.
- R3: Eligible streams are granted in rotating order, starting with the stream after the one granted last. Streams that are not eligible are skipped. Directly after reset the search starts at stream 0. With no eligible stream, the gateway stays idle.
- R4: A new block is granted only after a `drain_done` pulse has arrived following the forwarding of the previous block. The context read-back of a block also waits for that pulse.
- R5: Before any sample of a block, the gateway writes CTX_WORDS context words to addresses 0,1,...,CTX_WORDS-1 (`cfg_we` high, one word per cycle). These words are the stream's stored context, or all zeros if that stream has never been saved since reset.
- R6: After the drain pulse, the gateway issues CTX_WORDS reads (`cfg_re` high) to addresses 0,1,...,CTX_WORDS-1. `cfg_rdata` is taken in the same cycle as each read and kept as that stream's context for its next block.
- R7: A block forwards exactly n_s samples. For each one, `in_pop` of the served stream is high in the cycle the sample is taken, and in the next cycle `out_valid` is high with `out_data` equal to that stream's `in_data` and `out_stream` equal to the stream index.
- R8: The credit count starts at 2 after reset. Each forwarded sample uses one credit, and each cycle with `credit_ret` high returns one. No sample is forwarded while the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_size | input | NUM_STREAMS*CNT_W | Block size per stream, stream s in bits [s*CNT_W +: CNT_W] |
| in_level | input | NUM_STREAMS*CNT_W | Samples held in each input FIFO |
| in_data | input | NUM_STREAMS*DATA_W | Head sample of each input FIFO |
| in_pop | output | NUM_STREAMS | Pops the head of a FIFO at the clock edge |
| out_space | input | NUM_STREAMS*CNT_W | Free locations in each stream's consumer buffer |
| out_valid | output | 1 | A sample is on `out_data` this cycle |
| out_data | output | DATA_W | Sample sent into the accelerator chain |
| out_stream | output | STREAM_W | Stream currently granted the chain |
| credit_ret | input | 1 | One credit returned from downstream per high cycle |
| drain_done | input | 1 | Pulse from the exit side: the chain is empty |
| cfg_we | output | 1 | Context word write strobe |
| cfg_re | output | 1 | Context word read strobe |
| cfg_addr | output | WORD_W | Context word index |
| cfg_wdata | output | DATA_W | Context word being restored |
| cfg_rdata | input | DATA_W | Context word read back, valid in the cycle `cfg_re` is high |

## Verification
The hardest case to reach from the ports is a gateway that has finished forwarding while the chain has not yet reported empty. Only at that point do the drain gate and the deferred read-back matter. The bench holds back the modelled exit-side pulse and checks that neither a new context write nor any read appears, although another block is waiting for the same stream. It uses the same approach on the credit path, stopping credit returns partway through a block. The rotating order and skipping are checked from a log of which stream each context restore belongs to. The context path is checked with an accelerator model that changes every word it holds, so that each restore must carry the value saved for that stream, not a value left over from another stream.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [2:0] {
    S_ARB   = 3'd0,
    S_LOAD  = 3'd1,
    S_SEND  = 3'd2,
    S_DRAIN = 3'd3,
    S_SAVE  = 3'd4
  } seg_state_t;
endpackage

// File: rtl/seg_rr_arbiter.sv
module seg_rr_arbiter #(
  parameter int NS = 4,
  parameter int IW = 2
) (
  input  logic [NS-1:0] ready,
  input  logic [IW-1:0] last,
  output logic          gnt_valid,
  output logic [IW-1:0] gnt_idx
);
  // Scan from farthest to nearest so the stream right after 'last' wins.
  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int k = NS; k >= 1; k--) begin
      int c;
      c = (int'(last) + k) % NS;
      if (ready[c]) begin
        gnt_valid = 1'b1;
        gnt_idx   = IW'(c);
      end
    end
  end
endmodule

// File: rtl/seg_ctx_store.sv
module seg_ctx_store #(
  parameter int NS = 4,
  parameter int W  = 4,
  parameter int DW = 16,
  parameter int IW = 2,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] rd_sel,
  input  logic [AW-1:0] rd_word,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_sel,
  input  logic [AW-1:0] wr_word,
  input  logic [DW-1:0] wr_data
);
  localparam int DEPTH = NS * W;
  localparam int MAW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [NS-1:0] saved;
  logic [MAW-1:0] ra, wa;

  assign ra = MAW'(rd_sel) * MAW'(W) + MAW'(rd_word);
  assign wa = MAW'(wr_sel) * MAW'(W) + MAW'(wr_word);

  // Plain write port, no reset: fits distributed or block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wa] <= wr_data;
  end

  // One flag per stream marks a completed save; until then the context reads as zero.
  always_ff @(posedge clk) begin
    if (rst) saved <= '0;
    else if (wr_en && wr_word == AW'(W - 1)) saved[wr_sel] <= 1'b1;
  end

  assign rd_data = saved[rd_sel] ? mem[ra] : '0;
endmodule

// File: rtl/seg_credit.sv
module seg_credit #(
  parameter int INIT = 2,
  parameter int CW   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic ret,
  output logic avail
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= CW'(INIT);
    else cnt <= cnt - CW'(take) + CW'(ret);
  end

  assign avail = (cnt != '0);

  // R8
  take_with_credit_chk: assert property (@(posedge clk) disable iff (rst)
    take |-> cnt != '0);
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (ret && !take) |-> cnt < CW'(INIT));
endmodule

// File: rtl/stream_entry_gateway.sv
module stream_entry_gateway
  import seg_pkg::*;
#(
  parameter int NUM_STREAMS = 4,
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 8,
  parameter int CTX_WORDS   = 4,
  parameter int CREDITS     = 2,
  localparam int STREAM_W   = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
  localparam int WORD_W     = (CTX_WORDS > 1) ? $clog2(CTX_WORDS) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_STREAMS*CNT_W-1:0]  blk_size,
  input  logic [NUM_STREAMS*CNT_W-1:0]  in_level,
  input  logic [NUM_STREAMS*DATA_W-1:0] in_data,
  output logic [NUM_STREAMS-1:0]        in_pop,
  input  logic [NUM_STREAMS*CNT_W-1:0]  out_space,
  output logic                          out_valid,
  output logic [DATA_W-1:0]             out_data,
  output logic [STREAM_W-1:0]           out_stream,
  input  logic                          credit_ret,
  input  logic                          drain_done,
  output logic                          cfg_we,
  output logic                          cfg_re,
  output logic [WORD_W-1:0]             cfg_addr,
  output logic [DATA_W-1:0]             cfg_wdata,
  input  logic [DATA_W-1:0]             cfg_rdata
);
  localparam int CRED_W = $clog2(CREDITS + 1);

  seg_state_t          state;
  logic [STREAM_W-1:0] cur, rr_last;
  logic [WORD_W-1:0]   wcnt;
  logic [CNT_W-1:0]    sent;
  logic                drained;

  logic [CNT_W-1:0]  blk_a [NUM_STREAMS];
  logic [CNT_W-1:0]  lvl_a [NUM_STREAMS];
  logic [CNT_W-1:0]  spc_a [NUM_STREAMS];
  logic [DATA_W-1:0] dat_a [NUM_STREAMS];
  logic [NUM_STREAMS-1:0] ready;

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_unpack
    assign blk_a[g] = blk_size[g*CNT_W +: CNT_W];
    assign lvl_a[g] = in_level[g*CNT_W +: CNT_W];
    assign spc_a[g] = out_space[g*CNT_W +: CNT_W];
    assign dat_a[g] = in_data[g*DATA_W +: DATA_W];
    assign ready[g] = (blk_a[g] != '0) && (lvl_a[g] >= blk_a[g]) && (spc_a[g] >= blk_a[g]);
  end

  logic                gnt_valid;
  logic [STREAM_W-1:0] gnt_idx;

  seg_rr_arbiter #(.NS(NUM_STREAMS), .IW(STREAM_W)) u_arb (
    .ready    (ready),
    .last     (rr_last),
    .gnt_valid(gnt_valid),
    .gnt_idx  (gnt_idx)
  );

  logic credit_ok, send;
  logic [CNT_W-1:0] blk_cur;
  assign blk_cur = blk_a[cur];
  assign send    = (state == S_SEND) && credit_ok && (sent < blk_cur);

  seg_credit #(.INIT(CREDITS), .CW(CRED_W)) u_credit (
    .clk  (clk),
    .rst  (rst),
    .take (send),
    .ret  (credit_ret),
    .avail(credit_ok)
  );

  logic [DATA_W-1:0] ctx_rd;

  seg_ctx_store #(
    .NS(NUM_STREAMS), .W(CTX_WORDS), .DW(DATA_W), .IW(STREAM_W), .AW(WORD_W)
  ) u_ctx (
    .clk    (clk),
    .rst    (rst),
    .rd_sel (cur),
    .rd_word(wcnt),
    .rd_data(ctx_rd),
    .wr_en  (cfg_re),
    .wr_sel (cur),
    .wr_word(cfg_addr),
    .wr_data(cfg_rdata)
  );

  // FIFO pop acknowledges the head sample in the cycle it is taken.
  always_comb begin
    for (int k = 0; k < NUM_STREAMS; k++) in_pop[k] = send && (cur == STREAM_W'(k));
  end

  assign out_stream = cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_ARB;
      cur       <= '0;
      rr_last   <= STREAM_W'(NUM_STREAMS - 1);
      wcnt      <= '0;
      sent      <= '0;
      drained   <= 1'b1;
      out_valid <= 1'b0;
      out_data  <= '0;
      cfg_we    <= 1'b0;
      cfg_re    <= 1'b0;
      cfg_addr  <= '0;
      cfg_wdata <= '0;
    end else begin
      out_valid <= send;
      if (send) out_data <= dat_a[cur];
      cfg_we <= 1'b0;
      cfg_re <= 1'b0;
      if (drain_done) drained <= 1'b1;
      unique case (state)
        S_ARB: begin
          if (drained && gnt_valid) begin
            cur     <= gnt_idx;
            rr_last <= gnt_idx;
            wcnt    <= '0;
            state   <= S_LOAD;
          end
        end
        S_LOAD: begin
          cfg_we    <= 1'b1;
          cfg_addr  <= wcnt;
          cfg_wdata <= ctx_rd;
          if (wcnt == WORD_W'(CTX_WORDS - 1)) begin
            sent    <= '0;
            drained <= 1'b0;
            state   <= S_SEND;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        S_SEND: begin
          if (send) begin
            sent <= sent + 1'b1;
            if (sent == blk_cur - CNT_W'(1)) state <= S_DRAIN;
          end
        end
        S_DRAIN: begin
          if (drained) begin
            wcnt  <= '0;
            state <= S_SAVE;
          end
        end
        S_SAVE: begin
          cfg_re   <= 1'b1;
          cfg_addr <= wcnt;
          if (wcnt == WORD_W'(CTX_WORDS - 1)) state <= S_ARB;
          else wcnt <= wcnt + 1'b1;
        end
        default: state <= S_ARB;
      endcase
    end
  end

  // R4
  start_after_drain_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_we) |-> $past(drained));
  // R3
  grant_ready_chk: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> ready[gnt_idx]);
  // R7
  single_pop_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(in_pop));
  // R7
  pop_then_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (in_pop != '0) |=> out_valid);
  // R7
  block_len_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_SEND) |-> sent < blk_cur);
  // R6
  cfg_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && cfg_re));
endmodule

// File: tb/stream_entry_gateway_test.sv
module stream_entry_gateway_test;
  localparam int NS = 4;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int W  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [NS*CW-1:0] blk_size, in_level, out_space;
  logic [NS*DW-1:0] in_data;
  logic [NS-1:0]    in_pop;
  logic             out_valid;
  logic [DW-1:0]    out_data;
  logic [1:0]       out_stream;
  logic             credit_ret = 1'b0;
  logic             drain_done = 1'b0;
  logic             cfg_we, cfg_re;
  logic [1:0]       cfg_addr;
  logic [DW-1:0]    cfg_wdata;
  logic [DW-1:0]    cfg_rdata = '0;

  stream_entry_gateway uut (
    .clk(clk), .rst(rst), .blk_size(blk_size), .in_level(in_level), .in_data(in_data),
    .in_pop(in_pop), .out_space(out_space), .out_valid(out_valid), .out_data(out_data),
    .out_stream(out_stream), .credit_ret(credit_ret), .drain_done(drain_done),
    .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata)
  );

  int head [NS], lvl [NS], spc [NS], bs [NS], tot [NS], nstart_s [NS];
  int model [NS][W];
  int acc [W];
  int start_log [64];
  int n_starts = 0, n_rd = 0, ridx = 0, sidx = 0;
  int pend = 0, bcnt = 0, dtimer = 0;
  bit dpend = 0, hold_credit = 0, hold_drain = 0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      blk_size[s*CW +: CW]  = CW'(bs[s]);
      in_level[s*CW +: CW]  = CW'(lvl[s]);
      out_space[s*CW +: CW] = CW'(spc[s]);
      in_data[s*DW +: DW]   = {8'(s), 8'(head[s])};
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Environment models and continuous checks, all at the falling edge.
  always @(negedge clk) begin
    credit_ret = 1'b0;
    drain_done = 1'b0;
    if (!rst) begin
      if (cfg_we) begin
        if (ridx == 0) begin
          start_log[n_starts % 64] = int'(out_stream);
          n_starts++;
          nstart_s[out_stream]++;
        end
        chk(int'(cfg_addr) == ridx, "R5 restore address order", int'(cfg_addr), ridx);
        chk(int'(cfg_wdata) == model[out_stream][cfg_addr], "R5 restored context",
            int'(cfg_wdata), model[out_stream][cfg_addr]);
        acc[cfg_addr] = int'(cfg_wdata);
        ridx = (ridx + 1) % W;
      end
      if (cfg_re) begin
        chk(int'(cfg_addr) == sidx, "R6 save address order", int'(cfg_addr), sidx);
        cfg_rdata = DW'(acc[cfg_addr] + 1);
        model[out_stream][cfg_addr] = acc[cfg_addr] + 1;
        sidx = (sidx + 1) % W;
        n_rd++;
      end
      if (out_valid) begin
        chk(out_data == {8'(out_stream), 8'(head[out_stream])}, "R7 sample data",
            int'(out_data), int'({8'(out_stream), 8'(head[out_stream])}));
        head[out_stream]++;
        lvl[out_stream]--;
        tot[out_stream]++;
        pend++;
        chk(pend <= 2, "R8 outstanding credits", pend, 2);
        bcnt++;
        if (bcnt == bs[out_stream]) begin
          bcnt  = 0;
          dpend = 1'b1;
        end
      end
      if (!hold_credit && pend > 0) begin
        credit_ret = 1'b1;
        pend--;
      end
      if (dpend && !hold_drain) begin
        dtimer++;
        if (dtimer == 3) begin
          drain_done = 1'b1;
          dpend      = 1'b0;
          dtimer     = 0;
        end
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    cycles(1);
    chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    chk(in_pop == '0, "R1 in_pop in reset", int'(in_pop), 0);
    chk(cfg_we == 1'b0 && cfg_re == 1'b0, "R1 cfg strobes in reset", int'({cfg_we, cfg_re}), 0);
    rst = 1'b0;
    cycles(1);
    chk(out_valid == 1'b0 && cfg_we == 1'b0 && cfg_re == 1'b0 && in_pop == '0,
        "R1 idle after reset", int'({out_valid, cfg_we, cfg_re}), 0);
  endtask

  task automatic t_single;
    lvl[1] = 3; spc[1] = 8;
    cycles(60);
    chk(n_starts == 1, "R3 one block started", n_starts, 1);
    chk(start_log[0] == 1, "R2 eligible stream served", start_log[0], 1);
    chk(tot[1] == 3, "R7 block length", tot[1], 3);
    chk(n_rd == W, "R6 context words read back", n_rd, W);
  endtask

  task automatic t_rotate;
    int base;
    int exp_order [8] = '{2, 3, 0, 1, 2, 3, 0, 1};
    base = n_starts;
    for (int s = 0; s < NS; s++) begin lvl[s] = 6; spc[s] = 8; end
    cycles(400);
    chk(n_starts - base == 8, "R3 block count", n_starts - base, 8);
    for (int i = 0; i < 8; i++)
      chk(start_log[base + i] == exp_order[i], "R3 rotating order", start_log[base + i], exp_order[i]);
  endtask

  task automatic t_skip;
    int base;
    base = n_starts;
    lvl[0] = 3; lvl[2] = 3;
    cycles(120);
    chk(n_starts - base == 2, "R3 skip count", n_starts - base, 2);
    chk(start_log[base] == 2, "R3 skip first", start_log[base], 2);
    chk(start_log[base + 1] == 0, "R3 skip second", start_log[base + 1], 0);
  endtask

  task automatic t_gate;
    int base, t3, t0;
    base = n_starts; t3 = tot[3]; t0 = tot[0];
    lvl[3] = 3; spc[3] = 2;
    lvl[0] = 2;
    bs[2] = 0; lvl[2] = 5;
    cycles(100);
    chk(n_starts == base, "R2 no start when short", n_starts - base, 0);
    chk(tot[3] == t3 && tot[0] == t0, "R2 no samples when short", tot[3] - t3, 0);
    spc[3] = 3;
    cycles(60);
    chk(tot[3] - t3 == 3, "R2 space equal to block", tot[3] - t3, 3);
    lvl[0] = 3;
    cycles(60);
    chk(tot[0] - t0 == 3, "R2 level equal to block", tot[0] - t0, 3);
    chk(n_starts - base == 2, "R2 zero block size never served", n_starts - base, 2);
    lvl[2] = 0; bs[2] = 3;
  endtask

  task automatic t_drain;
    int base, rd0;
    hold_drain = 1'b1;
    lvl[1] = 6;
    cycles(30);
    base = n_starts; rd0 = n_rd;
    cycles(100);
    chk(n_starts == base, "R4 no start before drain", n_starts - base, 0);
    chk(n_rd == rd0, "R4 no read-back before drain", n_rd - rd0, 0);
    hold_drain = 1'b0;
    cycles(80);
    chk(n_starts - base == 1, "R4 start after drain", n_starts - base, 1);
    chk(n_rd - rd0 == 2 * W, "R6 read-back after drain", n_rd - rd0, 2 * W);
  endtask

  task automatic t_credit;
    int t0;
    t0 = tot[0];
    hold_credit = 1'b1;
    lvl[0] = 3;
    cycles(50);
    chk(tot[0] - t0 == 2, "R8 initial credits", tot[0] - t0, 2);
    hold_credit = 1'b0;
    cycles(60);
    chk(tot[0] - t0 == 3, "R8 resume on credit return", tot[0] - t0, 3);
  endtask

  task automatic t_context;
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < W; w++)
        chk(model[s][w] == nstart_s[s], "R6 saved context per stream", model[s][w], nstart_s[s]);
  endtask

  initial begin
    for (int s = 0; s < NS; s++) begin
      head[s] = 0; lvl[s] = 0; spc[s] = 0; bs[s] = 3; tot[s] = 0; nstart_s[s] = 0;
      for (int w = 0; w < W; w++) model[s][w] = 0;
    end
    for (int w = 0; w < W; w++) acc[w] = 0;
    cycles(4);
    t_reset;
    t_single;
    t_rotate;
    t_skip;
    t_gate;
    t_drain;
    t_credit;
    t_context;
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule